// File: doc/BRIEF.md
# Tagged-FIFO Frame Transmitter Controller

This block sits between a host-side byte source and a bit-level serializer that frames its output. Bytes enter a small transmit FIFO. Each entry carries one extra bit that marks the last byte of a frame. The controller hands bytes to the serializer one request at a time. It decides where each frame stops, using one of three sources:

- a software end flag, in programmed-I/O mode;
- a DMA terminal-count input, which applies whenever DMA is enabled;
- a frame length down-counter, which can be combined with either of the other two.

After the last byte, the controller asks the serializer for a good CRC and then a closing flag. Two further behaviours cover the error and pacing cases. If the FIFO runs dry in the middle of a frame, the controller aborts the frame with a corrupted CRC and a closing flag. It then drains the rest of that frame from the FIFO without sending it, and only then raises an underrun status. In stop-per-frame mode, the transmitter halts after every frame. It stays halted until software clears the halted bit, and the length register is sampled again when the next frame starts.

Top module: `frame_tx_ctrl`

## Requirements
- R1: In programmed-I/O mode (`dma_en`=0), a pulse on `eot_set` marks the next byte written as the last of its frame. So does `eot_set` asserted in the same cycle as the write. The mark is consumed by any write.
- R2: With `dma_en`=1, the end mark of every written byte equals `dma_tc` at the time of the write, and `eot_set` has no effect on it.
- R3: With `cnt_mode`=1, the length counter is loaded from `frame_len` when a frame starts and counts down for each byte that leaves the FIFO. A frame ends after `frame_len` bytes, or earlier at a byte that carries an end mark. A long block is therefore cut into equal frames followed by a shorter last frame.
- R4: When the last byte of a frame has been sent, the next request yields a `crc_good` pulse. The request after that yields a `flag_out` pulse.
- R5: A request during a frame while the FIFO is empty yields a `crc_bad` pulse. The next request yields `flag_out`. No byte is sent in between.
- R6: After an abort, the FIFO entries up to and including the end of the aborted frame are popped without any request and are never presented on `byte_vld`.
- R7: `urun` rises only in the cycle after the end of the aborted frame has been popped. A pulse on `urun_clr` clears it. While `urun` is 1, no new frame starts.
- R8: With `stop_mode`=1, `halted` rises together with the closing `flag_out` of a normal frame, and no new frame starts while it is set. A `restart` pulse clears it, and the next frame loads the `frame_len` value present at its start.
- R9: The FIFO holds `DEPTH` (16) entries. `fifo_lvl` gives the fill level. A write to a full FIFO is dropped. A write and a pop in the same cycle leave the level unchanged.
- R10: A `fifo_clr` pulse empties the FIFO and returns the controller to idle, so that a later request on an empty FIFO does not abort anything.
- R11: Every serializer-side output is a single-cycle pulse in the cycle after the clock edge that sampled `byte_req`. At most one of `byte_vld`, `crc_good`, `crc_bad` and `flag_out` is high at a time. `irq` equals `halted` OR `urun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous FIFO clear and controller return to idle |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | DW | Byte to write |
| dma_en | input | 1 | 1: all writes use DMA end selection |
| dma_tc | input | 1 | DMA terminal count, qualifies a write as last byte |
| eot_set | input | 1 | Software end-of-frame flag set pulse |
| cnt_mode | input | 1 | 1: the length counter also ends frames |
| frame_len | input | LENW | Frame length in bytes for counter mode |
| stop_mode | input | 1 | 1: halt after each frame |
| restart | input | 1 | Clears the halted bit |
| urun_clr | input | 1 | Clears the underrun bit |
| byte_req | input | 1 | Serializer ready for its next item |
| byte_vld | output | 1 | Data byte presented |
| byte_out | output | DW | Data byte |
| crc_good | output | 1 | Append normal CRC |
| crc_bad | output | 1 | Append inverted CRC (abort) |
| flag_out | output | 1 | Send closing flag |
| fifo_lvl | output | $clog2(DEPTH+1) | FIFO fill level |
| halted | output | 1 | Halted after frame in stop mode |
| urun | output | 1 | Underrun status |
| irq | output | 1 | Interrupt: halted or underrun |

## Verification
While the controller drains an aborted frame, it pops one entry per cycle. The bench writes new bytes in exactly the cycles where the drain pops the previous ones, so each push meets a pop on the same edge. It then checks that `fifo_lvl` stays at one. It also checks that `urun` rises on the edge where the end-marked byte is popped, while the byte written on that edge stays queued. The scoreboard also confirms that none of the drained bytes ever appears on `byte_vld`.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_DATA,
      S_CRCG,
      S_FLAG,
      S_AFLAG,
      S_FLUSH
   } ftx_state_e;
endpackage

// File: rtl/tx_tag_gen.sv
module tx_tag_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic dma_en,
   input  logic dma_tc,
   input  logic eot_set,
   output logic tag
);
   logic eot_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       eot_flag <= 1'b0;
      else if (wr_en)   eot_flag <= 1'b0;
      else if (eot_set) eot_flag <= 1'b1;
   end

   always_comb tag = dma_en ? dma_tc : (eot_flag | eot_set);
endmodule

// File: rtl/tx_tag_fifo.sv
module tx_tag_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic [$clog2(DEPTH+1)-1:0] lvl
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   initial begin
      depth_ok_chk: assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      width_ok_chk: assert (W >= 2) else $error("W must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          full, do_push, do_pop;

   always_comb begin
      empty   = (cnt == '0);
      full    = (cnt == CW'(DEPTH));
      do_pop  = pop && !empty;
      do_push = push && (!full || do_pop);
      dout    = mem[rp];
      lvl     = cnt;
   end

   generate
      if (POW2) begin : g_wrap_nat
         always_comb begin
            wp_nx = wp + 1'b1;
            rp_nx = rp + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_comb begin
            wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   // R9
   lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
   // R6
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
   import ftx_pkg::*;
#(
   parameter int DW   = 8,
   parameter int LENW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            byte_req,
   input  logic            empty,
   input  logic            head_tag,
   input  logic [DW-1:0]   head_data,
   input  logic [LENW-1:0] frame_len,
   input  logic            cnt_mode,
   input  logic            stop_mode,
   input  logic            restart,
   input  logic            urun_clr,
   output logic            pop,
   output logic            byte_vld,
   output logic [DW-1:0]   byte_out,
   output logic            crc_good,
   output logic            crc_bad,
   output logic            flag_out,
   output logic            halted,
   output logic            urun
);
   ftx_state_e      state;
   logic [LENW-1:0] cnt;
   logic            end_hit, start_last;

   always_comb begin
      end_hit    = head_tag || (cnt_mode && cnt == LENW'(1));
      start_last = head_tag || (cnt_mode && frame_len <= LENW'(1));
      pop = 1'b0;
      case (state)
         S_IDLE:  pop = byte_req && !empty && !halted && !urun;
         S_DATA:  pop = byte_req && !empty;
         S_FLUSH: pop = !empty;
         default: pop = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE; cnt <= '0; byte_out <= '0;
         byte_vld <= 1'b0; crc_good <= 1'b0; crc_bad <= 1'b0; flag_out <= 1'b0;
         halted <= 1'b0; urun <= 1'b0;
      end else begin
         byte_vld <= 1'b0; crc_good <= 1'b0; crc_bad <= 1'b0; flag_out <= 1'b0;
         if (restart)  halted <= 1'b0;
         if (urun_clr) urun <= 1'b0;
         if (clr) begin
            state <= S_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               S_IDLE: if (pop) begin
                  byte_vld <= 1'b1;
                  byte_out <= head_data;
                  cnt      <= frame_len - LENW'(1);
                  state    <= start_last ? S_CRCG : S_DATA;
               end
               S_DATA: if (byte_req) begin
                  if (empty) begin
                     crc_bad <= 1'b1;
                     state   <= S_AFLAG;
                  end else begin
                     byte_vld <= 1'b1;
                     byte_out <= head_data;
                     cnt      <= cnt - LENW'(1);
                     state    <= end_hit ? S_CRCG : S_DATA;
                  end
               end
               S_CRCG: if (byte_req) begin
                  crc_good <= 1'b1;
                  state    <= S_FLAG;
               end
               S_FLAG: if (byte_req) begin
                  flag_out <= 1'b1;
                  state    <= S_IDLE;
                  if (stop_mode) halted <= 1'b1;
               end
               S_AFLAG: if (byte_req) begin
                  flag_out <= 1'b1;
                  state    <= S_FLUSH;
               end
               S_FLUSH: if (pop) begin
                  cnt <= cnt - LENW'(1);
                  if (end_hit) begin
                     urun  <= 1'b1;
                     state <= S_IDLE;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   // R11
   one_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byte_vld, crc_good, crc_bad, flag_out}));
   // R5
   abort_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crc_bad |=> !byte_vld);
   // R7
   urun_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(urun) |-> $past(state == S_FLUSH));
   // R8
   halt_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> flag_out);
endmodule

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   parameter int LENW  = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fifo_clr,
   input  logic                       wr_en,
   input  logic [DW-1:0]              wr_data,
   input  logic                       dma_en,
   input  logic                       dma_tc,
   input  logic                       eot_set,
   input  logic                       cnt_mode,
   input  logic [LENW-1:0]            frame_len,
   input  logic                       stop_mode,
   input  logic                       restart,
   input  logic                       urun_clr,
   input  logic                       byte_req,
   output logic                       byte_vld,
   output logic [DW-1:0]              byte_out,
   output logic                       crc_good,
   output logic                       crc_bad,
   output logic                       flag_out,
   output logic [$clog2(DEPTH+1)-1:0] fifo_lvl,
   output logic                       halted,
   output logic                       urun,
   output logic                       irq
);
   localparam int EW = DW + 1;

   initial begin
      len_ok_chk: assert (LENW >= 2) else $error("LENW must be at least 2");
   end

   logic          wr_tag, pop, empty;
   logic [EW-1:0] head;

   tx_tag_gen i_tag (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .dma_en(dma_en),
      .dma_tc(dma_tc), .eot_set(eot_set), .tag(wr_tag)
   );

   tx_tag_fifo #(.W(EW), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(wr_en),
      .din({wr_tag, wr_data}), .pop(pop), .dout(head), .empty(empty), .lvl(fifo_lvl)
   );

   tx_frame_fsm #(.DW(DW), .LENW(LENW)) i_fsm (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .byte_req(byte_req),
      .empty(empty), .head_tag(head[DW]), .head_data(head[DW-1:0]),
      .frame_len(frame_len), .cnt_mode(cnt_mode), .stop_mode(stop_mode),
      .restart(restart), .urun_clr(urun_clr), .pop(pop),
      .byte_vld(byte_vld), .byte_out(byte_out), .crc_good(crc_good),
      .crc_bad(crc_bad), .flag_out(flag_out), .halted(halted), .urun(urun)
   );

   always_comb irq = halted | urun;
endmodule

// File: tb/test_frame_tx_ctrl.sv
module test_frame_tx_ctrl;
   logic clk = 0, rst_n = 0;
   logic fifo_clr = 0, wr_en = 0, dma_en = 0, dma_tc = 0, eot_set = 0;
   logic cnt_mode = 0, stop_mode = 0, restart = 0, urun_clr = 0, byte_req = 0;
   logic [7:0]  wr_data = 0;
   logic [11:0] frame_len = 12'd1;
   logic byte_vld, crc_good, crc_bad, flag_out, halted, urun, irq;
   logic [7:0] byte_out;
   logic [4:0] fifo_lvl;

   int n_chk = 0, n_fail = 0;
   int exp_q[$];
   string tag_q[$];

   localparam int C_GOOD = 256, C_BAD = 512, C_FLAG = 768;

   always #5 clk = ~clk;

   frame_tx_ctrl i_frame_tx_ctrl (
      .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .wr_en(wr_en), .wr_data(wr_data),
      .dma_en(dma_en), .dma_tc(dma_tc), .eot_set(eot_set), .cnt_mode(cnt_mode),
      .frame_len(frame_len), .stop_mode(stop_mode), .restart(restart),
      .urun_clr(urun_clr), .byte_req(byte_req), .byte_vld(byte_vld),
      .byte_out(byte_out), .crc_good(crc_good), .crc_bad(crc_bad),
      .flag_out(flag_out), .fifo_lvl(fifo_lvl), .halted(halted), .urun(urun), .irq(irq)
   );

   task automatic chk(string r, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   task automatic expect_item(int code, string r);
      exp_q.push_back(code);
      tag_q.push_back(r);
   endtask

   task automatic expect_frame(int first, int n, string r);
      for (int i = 0; i < n; i++) expect_item((first + i) & 8'hFF, r);
      expect_item(C_GOOD, "R4");
      expect_item(C_FLAG, "R4");
   endtask

   // monitor: pops the scoreboard whenever the design presents an item
   always @(negedge clk) begin
      if (rst_n && (byte_vld || crc_good || crc_bad || flag_out)) begin
         int code;
         code = byte_vld ? int'(byte_out) : crc_good ? C_GOOD : crc_bad ? C_BAD : C_FLAG;
         if (exp_q.size() == 0) chk("R11 unexpected item", code, -1);
         else begin
            string t;
            t = tag_q.pop_front();
            chk(t, code, exp_q.pop_front());
         end
      end
   end

   task automatic wr(int d, bit tc, bit eot);
      wr_en = 1; wr_data = 8'(d); dma_tc = tc; eot_set = eot;
      @(negedge clk);
      wr_en = 0; dma_tc = 0; eot_set = 0;
   endtask

   task automatic reqs(int n);
      byte_req = 1;
      repeat (n) @(negedge clk);
      byte_req = 0;
   endtask

   task automatic pulse(ref logic s);
      s = 1;
      @(negedge clk);
      s = 0;
   endtask

   task automatic drained(string r);
      repeat (2) @(negedge clk);
      chk(r, exp_q.size(), 0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R9 reset level", int'(fifo_lvl), 0);
      chk("R11 reset irq", int'(irq), 0);
      chk("R11 reset outputs", int'({byte_vld, crc_good, crc_bad, flag_out}), 0);

      // R1 software end flag in PIO mode
      wr(8'hA0, 0, 0); wr(8'hA1, 0, 0);
      pulse(eot_set);
      wr(8'hA2, 0, 0);
      expect_frame(8'hA0, 3, "R1");
      reqs(8);
      drained("R1 frame complete");
      chk("R1 level", int'(fifo_lvl), 0);

      // R2 DMA mode: terminal count decides, eot_set ignored
      dma_en = 1;
      pulse(eot_set);
      wr(8'hB0, 0, 0); wr(8'hB1, 1, 0);
      expect_frame(8'hB0, 2, "R2");
      reqs(8);
      drained("R2 frame complete");

      // R3 counter mode splits block, short last frame on terminal count
      cnt_mode = 1; frame_len = 12'd3;
      for (int i = 0; i < 7; i++) wr(8'hC0 + i, i == 6, 0);
      expect_frame(8'hC0, 3, "R3");
      expect_frame(8'hC3, 3, "R3");
      expect_frame(8'hC6, 1, "R3");
      reqs(20);
      drained("R3 split frames");

      // R8 stop mode, length re-sampled on restart
      stop_mode = 1; frame_len = 12'd2;
      for (int i = 0; i < 4; i++) wr(8'h10 + i, 0, 0);
      expect_frame(8'h10, 2, "R8");
      reqs(10);
      drained("R8 first frame");
      chk("R8 halted", int'(halted), 1);
      chk("R11 irq on halt", int'(irq), 1);
      chk("R8 no start while halted", int'(fifo_lvl), 2);
      frame_len = 12'd1;
      pulse(restart);
      expect_frame(8'h12, 1, "R8");
      reqs(6);
      drained("R8 second frame");
      chk("R8 halted again", int'(halted), 1);
      pulse(restart);
      expect_frame(8'h13, 1, "R8");
      reqs(6);
      drained("R8 third frame");
      stop_mode = 0;
      pulse(restart);
      chk("R8 restart clears", int'(halted), 0);

      // R5 R6 R7 underrun, abort, silent drain, push and pop together
      cnt_mode = 0; dma_en = 0;
      wr(8'h40, 0, 0); wr(8'h41, 0, 0);
      expect_item(8'h40, "R5"); expect_item(8'h41, "R5");
      expect_item(C_BAD, "R5"); expect_item(C_FLAG, "R5");
      reqs(4);
      drained("R5 abort sequence");
      chk("R7 not yet set", int'(urun), 0);
      wr(8'h42, 0, 0);
      wr(8'h43, 0, 1);
      chk("R9 push with pop level", int'(fifo_lvl), 1);
      wr(8'h50, 0, 1);
      chk("R9 push with pop level", int'(fifo_lvl), 1);
      chk("R7 set at frame end", int'(urun), 1);
      chk("R11 irq on underrun", int'(irq), 1);
      reqs(5);
      chk("R7 no start while set", int'(fifo_lvl), 1);
      pulse(urun_clr);
      chk("R7 cleared", int'(urun), 0);
      expect_frame(8'h50, 1, "R6");
      reqs(6);
      drained("R6 next frame after drain");

      // R9 full FIFO drops write
      for (int i = 0; i < 15; i++) wr(8'h60 + i, 0, 0);
      wr(8'h6F, 0, 1);
      wr(8'hEE, 0, 1);
      chk("R9 full level", int'(fifo_lvl), 16);
      expect_frame(8'h60, 16, "R9");
      reqs(20);
      drained("R9 drop on full");
      chk("R9 empty after", int'(fifo_lvl), 0);

      // R10 clear mid-frame, R11 response timing
      wr(8'h70, 0, 0); wr(8'h71, 0, 0);
      expect_item(8'h70, "R11");
      byte_req = 1;
      @(negedge clk);
      byte_req = 0;
      chk("R11 byte next cycle", int'(byte_vld), 1);
      @(negedge clk);
      chk("R11 single pulse", int'(byte_vld), 0);
      pulse(fifo_clr);
      chk("R10 level cleared", int'(fifo_lvl), 0);
      reqs(3);
      drained("R10 no abort after clear");
      wr(8'h80, 0, 1);
      expect_frame(8'h80, 1, "R10");
      reqs(5);
      drained("R10 fresh frame");

      finish_run();
   end
endmodule